// File: doc/BRIEF.md
# FPGA Passive Configuration Loader

This block loads a configuration bitstream into a target FPGA that waits passively for its image. A host issues a start command with a mode code and a byte count, then feeds bytes through a valid/ready stream. The loader first pulses the target's configuration-reset pin low. It waits for the target to settle, then clocks each byte onto the target's data pins with a configuration clock that it generates itself. After the last byte it checks that the target has accepted the image.

Three clocking modes are supported. In serial mode a byte goes out bit by bit on one data line. In parallel mode a whole byte is clocked in one pulse. The secured parallel mode adds three more pulses per byte for targets that decrypt their image. The target's status pin is checked before every byte. After the stream, one trailing clock edge is issued, and after a settle time the target's done pin decides success or failure. The bytes sent so far stay readable after a failure. All delays are given in microseconds and converted into cycles from a clock-frequency parameter.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start with a byte count of zero, or with mode code 3, sets `error_o` on the next cycle. It leaves `busy_o` low and causes no activity on `ncfg_o` or `dclk_o`.
- R2: An accepted start drives `ncfg_o` low for at least RESET_US microseconds, counted in cycles from CLK_FREQ_HZ, then releases it high.
- R3: After `ncfg_o` rises, the first `dclk_o` rising edge comes at least WAIT_US microseconds later. `dclk_o` is low whenever `ncfg_o` is low and when the data phase begins.
- R4: `data_o` changes only while `dclk_o` is low. Every high and every low phase of `dclk_o` in the data phase lasts at least HALF_CYCLES cycles.
- R5: Mode 0 (serial) sends each byte on `data_o[0]` over 8 `dclk_o` pulses, bit 0 first, with `data_o[7:1]` held at zero.
- R6: Mode 1 (parallel) presents the whole byte on `data_o` and clocks it with exactly one `dclk_o` pulse.
- R7: Mode 2 (secured parallel) clocks each byte with one data pulse followed by three more pulses, and holds the byte on `data_o` throughout.
- R8: If `nstatus_i` is low when the next byte is due, the load stops. `abort_o` pulses for one cycle, `error_o` is set, no further `dclk_o` edges follow, and `bytes_sent_o` keeps the number of bytes fully clocked.
- R9: After the last byte, one more `dclk_o` rising edge is issued. At least WAIT_US microseconds later `conf_done_i` is sampled: high sets `done_o`, low sets `error_o` and pulses `abort_o`.
- R10: A byte is taken only when `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only while the loader is busy and waiting for a byte with `dclk_o` low. Without a valid byte the loader holds `dclk_o` low and does not advance.
- R11: `busy_o` is high from an accepted start until the result is known. `done_o` and `error_o` are never high together, and each stays set until the next start. `bytes_sent_o` only steps up by one or returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken while idle |
| mode_i | input | 2 | 0 serial, 1 parallel, 2 secured parallel, 3 rejected |
| byte_count_i | input | CNT_W | Number of bitstream bytes |
| s_data_i | input | DW | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Loader takes the byte this cycle |
| ncfg_o | output | 1 | Target configuration reset, active low |
| dclk_o | output | 1 | Target configuration clock |
| data_o | output | DW | Target data pins (bit 0 only in serial mode) |
| nstatus_i | input | 1 | Target status, low means error |
| conf_done_i | input | 1 | Target reports configuration complete |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| error_o | output | 1 | Last start or load failed |
| abort_o | output | 1 | One-cycle abort pulse on a failed load |
| bytes_sent_o | output | CNT_W | Bytes fully clocked in the current or last load |

## Verification
On every cycle the assertions check several pin and status rules. Data stays steady while the clock is high, the clock stays quiet during the reset pulse, and the stream is accepted only with the clock low. Done and error never show together, an abort always comes with an error, the byte counter moves one step at a time, and rejected starts cause no pin activity. The bench scenarios are needed for the rest. They rebuild each byte from the sampled pins in all three modes, count clock pulses against the byte count, and measure the reset pulse, the settle waits and the half-periods. They also cover a status failure partway through a load, a missing done indication, and stream stalls.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [1:0] {
    MODE_SERIAL  = 2'd0,
    MODE_PAR     = 2'd1,
    MODE_PAR_SEC = 2'd2,
    MODE_RSVD    = 2'd3
  } cfg_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NCFG_LOW,
    ST_NCFG_WAIT,
    ST_FETCH,
    ST_CLK_LOW,
    ST_CLK_HIGH,
    ST_TAIL_LOW,
    ST_FINAL
  } cfg_state_e;

  localparam int SEC_EXTRA_PULSES = 3;
endpackage

// File: rtl/cfg_ldr_timer.sv
module cfg_ldr_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] cycles,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= cycles - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfg_ldr_lane.sv
module cfg_ldr_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic          serial,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] shreg;
  logic [BW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      idx    <= '0;
      data_o <= '0;
    end else if (load) begin
      shreg  <= byte_i;
      idx    <= '0;
      data_o <= serial ? {{(DW-1){1'b0}}, byte_i[0]} : byte_i;
    end else if (shift) begin
      shreg  <= shreg >> 1;
      idx    <= idx + 1'b1;
      data_o <= {{(DW-1){1'b0}}, shreg[1]};
    end
  end

  assign last_o = !serial || (idx == BW'(DW-1));
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int RESET_US    = 5,
  parameter int WAIT_US     = 100,
  parameter int HALF_CYCLES = 2,
  parameter int DW          = 8,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [DW-1:0]    s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             ncfg_o,
  output logic             dclk_o,
  output logic [DW-1:0]    data_o,
  input  logic             nstatus_i,
  input  logic             conf_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] bytes_sent_o
);
  import cfg_ldr_pkg::*;

  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int RST_RAW    = CYC_PER_US * RESET_US;
  localparam int WAIT_RAW   = CYC_PER_US * WAIT_US;
  localparam int RST_CYC    = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam int WAIT_CYC   = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int HALF_CYC   = (HALF_CYCLES < 1) ? 1 : HALF_CYCLES;
  localparam int MAX_A      = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int MAX_CYC    = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int TMR_W      = $clog2(MAX_CYC + 1);
  localparam int EXW        = $clog2(SEC_EXTRA_PULSES + 1);

  cfg_state_e       st;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] total_q;
  logic [EXW-1:0]   extra_q;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_exp;
  logic             lane_load;
  logic             lane_shift;
  logic             lane_last;
  logic             start_ok;
  logic             all_sent;
  logic             is_serial;
  logic             is_secure;

  assign start_ok  = (byte_count_i != '0) && (cfg_mode_e'(mode_i) != MODE_RSVD);
  assign all_sent  = (bytes_sent_o == total_q);
  assign is_serial = (cfg_mode_e'(mode_q) == MODE_SERIAL);
  assign is_secure = (cfg_mode_e'(mode_q) == MODE_PAR_SEC);

  assign s_ready_o  = (st == ST_FETCH) && !all_sent && nstatus_i;
  assign lane_load  = s_ready_o && s_valid_i;
  assign lane_shift = (st == ST_CLK_HIGH) && tmr_exp && !lane_last;

  // timer reload strobes follow the state transitions below
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(HALF_CYC);
    unique case (st)
      ST_IDLE: begin
        if (start_i && start_ok) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RST_CYC);
        end
      end
      ST_NCFG_LOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(WAIT_CYC);
        end
      end
      ST_FETCH:    tmr_load = all_sent || lane_load;
      ST_CLK_LOW:  tmr_load = tmr_exp;
      ST_CLK_HIGH: tmr_load = tmr_exp && (!lane_last || (extra_q != '0));
      ST_TAIL_LOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(WAIT_CYC);
        end
      end
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      mode_q       <= '0;
      total_q      <= '0;
      extra_q      <= '0;
      ncfg_o       <= 1'b1;
      dclk_o       <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      error_o      <= 1'b0;
      abort_o      <= 1'b0;
      bytes_sent_o <= '0;
    end else begin
      abort_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            done_o <= 1'b0;
            if (start_ok) begin
              error_o      <= 1'b0;
              busy_o       <= 1'b1;
              ncfg_o       <= 1'b0;
              bytes_sent_o <= '0;
              total_q      <= byte_count_i;
              mode_q       <= mode_i;
              st           <= ST_NCFG_LOW;
            end else begin
              error_o <= 1'b1;
            end
          end
        end
        ST_NCFG_LOW: begin
          if (tmr_exp) begin
            ncfg_o <= 1'b1;
            st     <= ST_NCFG_WAIT;
          end
        end
        ST_NCFG_WAIT: begin
          if (tmr_exp) st <= ST_FETCH;
        end
        ST_FETCH: begin
          if (all_sent) begin
            st <= ST_TAIL_LOW;
          end else if (!nstatus_i) begin
            error_o <= 1'b1;
            abort_o <= 1'b1;
            busy_o  <= 1'b0;
            st      <= ST_IDLE;
          end else if (s_valid_i) begin
            extra_q <= is_secure ? EXW'(SEC_EXTRA_PULSES) : '0;
            st      <= ST_CLK_LOW;
          end
        end
        ST_CLK_LOW: begin
          if (tmr_exp) begin
            dclk_o <= 1'b1;
            st     <= ST_CLK_HIGH;
          end
        end
        ST_CLK_HIGH: begin
          if (tmr_exp) begin
            dclk_o <= 1'b0;
            if (!lane_last) begin
              st <= ST_CLK_LOW;
            end else if (extra_q != '0) begin
              extra_q <= extra_q - 1'b1;
              st      <= ST_CLK_LOW;
            end else begin
              bytes_sent_o <= bytes_sent_o + 1'b1;
              st           <= ST_FETCH;
            end
          end
        end
        ST_TAIL_LOW: begin
          if (tmr_exp) begin
            dclk_o <= 1'b1;
            st     <= ST_FINAL;
          end
        end
        ST_FINAL: begin
          if (tmr_exp) begin
            dclk_o <= 1'b0;
            busy_o <= 1'b0;
            st     <= ST_IDLE;
            if (conf_done_i) begin
              done_o <= 1'b1;
            end else begin
              error_o <= 1'b1;
              abort_o <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  cfg_ldr_timer #(.W(TMR_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .cycles  (tmr_val),
    .expired (tmr_exp)
  );

  cfg_ldr_lane #(.DW(DW)) lane_i (
    .clk    (clk),
    .rst    (rst),
    .load   (lane_load),
    .shift  (lane_shift),
    .serial (is_serial),
    .byte_i (s_data_i),
    .data_o (data_o),
    .last_o (lane_last)
  );
endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] byte_count_i,
  input logic             s_ready_o,
  input logic             ncfg_o,
  input logic             dclk_o,
  input logic [DW-1:0]    data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             error_o,
  input logic             abort_o,
  input logic [CNT_W-1:0] bytes_sent_o
);
  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && ((byte_count_i == '0) || (mode_i == 2'd3)))
      |=> (error_o && !busy_o && ncfg_o && !dclk_o));

  assert_clk_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    !ncfg_o |-> !dclk_o);

  assert_data_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
    dclk_o |-> $stable(data_o));

  assert_abort_means_error_R8: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (error_o && !busy_o));

  assert_ready_with_clk_low_R10: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> (!dclk_o && busy_o && ncfg_o));

  assert_result_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));

  assert_count_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (bytes_sent_o != $past(bytes_sent_o))
      |-> ((bytes_sent_o == $past(bytes_sent_o) + 1'b1) || (bytes_sent_o == '0)));
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/fpga_cfg_loader_tb_top.sv
module fpga_cfg_loader_tb_top;
  localparam int FREQ   = 10_000_000;
  localparam int RST_E  = 50;
  localparam int WAIT_E = 1000;
  localparam int HALF   = 2;
  localparam int MAXR   = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] byte_count_i = '0;
  logic [7:0]  s_data_i = '0;
  logic        s_valid_i = 1'b0;
  logic        s_ready_o;
  logic        ncfg_o, dclk_o;
  logic [7:0]  data_o;
  logic        nstatus_i = 1'b1;
  logic        conf_done_i = 1'b1;
  logic        busy_o, done_o, error_o, abort_o;
  logic [31:0] bytes_sent_o;

  always #4 clk = ~clk;

  fpga_cfg_loader #(.CLK_FREQ_HZ(FREQ), .RESET_US(5), .WAIT_US(100),
                    .HALF_CYCLES(HALF), .DW(8), .CNT_W(32)) dut_i (.*);

  int checks = 0;
  int errors = 0;

  // pin monitor
  int cyc = 0;
  int ncfg_low, ncfg_rise_cyc, first_gap, rise_cnt, last_rise, fin_cyc;
  int low_run, high_run, min_low, min_high, pin_act, abort_cnt;
  logic [7:0] rise_data [MAXR];
  logic prev_dclk = 1'b0, prev_ncfg = 1'b1, prev_fin = 1'b0;
  logic [7:0] mem [64];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!ncfg_o) ncfg_low++;
      if (ncfg_o && !prev_ncfg) ncfg_rise_cyc = cyc;
      if (dclk_o && !prev_dclk) begin
        if (rise_cnt == 0) first_gap = cyc - ncfg_rise_cyc;
        else if (low_run < min_low) min_low = low_run;
        if (rise_cnt < MAXR) rise_data[rise_cnt] = data_o;
        rise_cnt++;
        last_rise = cyc;
        high_run = 0;
      end
      if (!dclk_o && prev_dclk) begin
        if (high_run < min_high) min_high = high_run;
        low_run = 0;
      end
      if (dclk_o) high_run++; else low_run++;
      if (!ncfg_o || dclk_o) pin_act++;
      if (abort_o) abort_cnt++;
      if ((done_o || error_o) && !prev_fin) fin_cyc = cyc;
      prev_dclk = dclk_o;
      prev_ncfg = ncfg_o;
      prev_fin  = done_o || error_o;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pulses_per_byte(input int mode);
    if (mode == 0) return 8;
    if (mode == 1) return 1;
    return 4;
  endfunction

  function automatic string mode_req(input int mode);
    if (mode == 0) return "R5";
    if (mode == 1) return "R6";
    return "R7";
  endfunction

  task automatic clear_mon();
    ncfg_low = 0; first_gap = 0; rise_cnt = 0; last_rise = 0; fin_cyc = 0;
    low_run = 0; high_run = 0; min_low = 1 << 30; min_high = 1 << 30;
    pin_act = 0; abort_cnt = 0; ncfg_rise_cyc = 0;
  endtask

  task automatic issue_start(input int mode, input int n);
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'(mode); byte_count_i = 32'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drive_stream(input int n);
    for (int i = 0; i < n; i++) begin
      int gap = int'($urandom % 4);
      repeat (gap) begin
        @(negedge clk);
        s_valid_i = 1'b0;
      end
      @(negedge clk);
      s_valid_i = 1'b1;
      s_data_i  = mem[i];
      while (!s_ready_o && busy_o) @(negedge clk);
      if (!busy_o) break;
      @(posedge clk);
    end
    @(negedge clk);
    s_valid_i = 1'b0;
  endtask

  task automatic kill_status(input int at);
    if (at > 0) begin
      while (!(busy_o && bytes_sent_o == 32'(at))) @(negedge clk);
      nstatus_i = 1'b0;
    end
  endtask

  task automatic run_load(input int mode, input int n, input int fail_at, input bit conf_ok);
    int ppb = pulses_per_byte(mode);
    int nsent = (fail_at >= 0) ? fail_at : n;
    bit exp_ok = conf_ok && (fail_at < 0);
    int exp_rises = nsent * ppb + ((fail_at < 0) ? 1 : 0);
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    clear_mon();
    conf_done_i = conf_ok;
    nstatus_i   = (fail_at == 0) ? 1'b0 : 1'b1;
    issue_start(mode, n);
    chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
    fork
      drive_stream(n);
      kill_status(fail_at);
    join
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_o == exp_ok, "R9/R11 done_o", done_o, exp_ok);
    chk(error_o == !exp_ok, "R9/R11 error_o", error_o, !exp_ok);
    chk(abort_cnt == (exp_ok ? 0 : 1), "R8/R9 abort pulses", abort_cnt, exp_ok ? 0 : 1);
    chk(bytes_sent_o == 32'(nsent), "R8/R11 bytes_sent_o", bytes_sent_o, nsent);
    chk(rise_cnt == exp_rises, {mode_req(mode), " dclk rising edges"}, rise_cnt, exp_rises);
    chk(ncfg_low >= RST_E, "R2 ncfg low cycles", ncfg_low, RST_E);
    if (rise_cnt > 0) chk(first_gap >= WAIT_E, "R3 wait before first dclk", first_gap, WAIT_E);
    if (rise_cnt > 1) begin
      chk(min_low >= HALF, "R4 min dclk low", min_low, HALF);
      chk(min_high >= HALF, "R4 min dclk high", min_high, HALF);
    end
    if (fail_at < 0) chk(fin_cyc - last_rise >= WAIT_E, "R9 wait after trailing edge",
                         fin_cyc - last_rise, WAIT_E);
    for (int b = 0; b < nsent; b++) begin
      logic [7:0] got = '0;
      bit extra_ok = 1'b1;
      if (mode == 0) begin
        for (int j = 0; j < 8; j++) begin
          got[j] = rise_data[b*8+j][0];
          if (rise_data[b*8+j][7:1] != 7'd0) extra_ok = 1'b0;
        end
      end else if (mode == 1) begin
        got = rise_data[b];
      end else begin
        got = rise_data[b*4];
        for (int j = 1; j < 4; j++) if (rise_data[b*4+j] != got) extra_ok = 1'b0;
      end
      chk(got == mem[b] && extra_ok, {mode_req(mode), " byte on pins"}, got, mem[b]);
    end
    nstatus_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(done_o == exp_ok && error_o == !exp_ok, "R11 result sticky", done_o, exp_ok);
  endtask

  task automatic run_reject(input int mode, input int n);
    clear_mon();
    issue_start(mode, n);
    repeat (3) @(negedge clk);
    chk(error_o == 1'b1, "R1 reject error_o", error_o, 1);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reject busy/done", busy_o, 0);
    chk(pin_act == 0, "R1 reject pin activity", pin_act, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ncfg_o == 1'b1 && dclk_o == 1'b0, "R3 reset pins", {ncfg_o, dclk_o}, 2);
    chk(busy_o == 0 && done_o == 0 && error_o == 0 && s_ready_o == 0,
        "R11 reset status", {busy_o, done_o, error_o, s_ready_o}, 0);
    chk(bytes_sent_o == 0, "R11 reset count", bytes_sent_o, 0);

    run_reject(1, 0);
    run_reject(3, 6);
    run_load(0, 3, -1, 1'b1);
    run_load(1, 5, -1, 1'b1);
    run_load(2, 4, -1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      int m = int'($urandom % 3);
      int n = 1 + int'($urandom % 12);
      run_load(m, n, -1, 1'b1);
    end
    run_load(1, 8, 3, 1'b1);   // status drops after three bytes, R8
    run_load(2, 5, 0, 1'b1);   // status low before the first byte, R8
    run_load(0, 2, -1, 1'b0);  // done pin stays low, R9
    run_load(1, 1, -1, 1'b1);  // single byte recovers after failures, R10

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule